// File: doc/BRIEF.md
# Single-Channel Burst DMA Controller

This block is one DMA channel. It copies a block of words between a memory port and an I/O port, and no processor is involved while the data moves. The processor programs the channel through three registers. One holds the current memory word address, one holds the remaining word count, and one holds the control and status flags. A write to the control register with the start flag set launches the transfer at once.

While a transfer runs, the channel asks for the system bus through a request/grant handshake. After each grant it moves up to `BURST_LEN` words back to back, one word per clock. It then drops its request for a cycle so that other masters can take the bus, and asks again while words remain. A transparent mode restricts word moves to cycles in which the system bus reports itself idle. When the count reaches zero the channel goes back to idle, sets an interrupt status flag, and drives its interrupt line if interrupts are enabled.

The controller is a four-state machine. `ST_IDLE` waits for a start. `ST_REQ` holds the bus request until a grant arrives. `ST_BURST` moves words while the grant is present. `ST_GAP` is a one-cycle release of the bus between bursts. The transitions are:
- IDLE→REQ on a start with a non-zero count.
- REQ→BURST on grant.
- BURST→GAP after the last beat of a burst when words remain.
- BURST→IDLE after the final word.
- GAP→REQ unconditionally.

A start with a zero count completes in `ST_IDLE` without any bus request.

Top module: `burst_dma_channel`

## Requirements
- R1: After reset, all three registers read as zero. `bus_req`, `irq` and all four port strobes (`mem_rd`, `mem_wr`, `io_rd`, `io_wr`) are low.
- R2: Register select 0 is the address and select 1 is the count. Select 2 is control: bit0 start (write-only, reads 0), bit1 direction, bit2 interrupt enable, bit3 transparent mode, bit4 interrupt status, bit5 busy (read-only). With direction 1, each word is read from memory at the address register and written to the I/O port. With direction 0, each word is read from the I/O port and written to memory. Each word adds one to the address and takes one from the count.
- R3: `bus_req` is high in the cycle after the start write. No word moves in a cycle without `bus_grant`.
- R4: Words move back to back, at most `BURST_LEN` per request. The request then drops for at least one cycle and is raised again while words remain.
- R5: With transparent mode set, words move only in cycles where `bus_idle` is high.
- R6: After the last word, the channel is idle (busy reads 0), `bus_req` is low, the interrupt status is set, and a new start is accepted.
- R7: `irq` is high exactly when both the interrupt status and the interrupt enable are set. Writing control with bit4 set clears the status.
- R8: Writes to the address or count register, and changes to the direction or transparent bits, are ignored while busy.
- R9: A start with a count of zero raises no bus request and sets the interrupt status in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 address, 1 count, 2 control) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_sel` (combinational) |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| bus_idle | input | 1 | System bus idle indication for transparent mode |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | DW | I/O write data |
| io_rdata | input | DW | I/O read data, valid in the same cycle |
| irq | output | 1 | Completion interrupt |

## Verification
A start write at one edge puts `bus_req` high after that edge. With the grant returned in the same cycle, the first word moves in the following cycle, and successive words move on consecutive edges. The interrupt status, the cleared busy flag and `irq` are all visible right after the edge that moves the last word. Status clears and enable changes show after the register write edge. The bench drives and samples only at falling edges, so each check reads these registered results half a period after the edge that produced them. It either polls the busy flag before comparing the moved data or checks at the exact cycle counted from the write.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BURST = 2'd2,
        ST_GAP   = 2'd3
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_IE    = 2;
    localparam int CB_TMODE = 3;
    localparam int CB_IRQ   = 4;
    localparam int CB_BUSY  = 5;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          move,
    input  logic          done,
    output logic          start,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_count,
    output logic          dir,
    output logic          ie,
    output logic          tmode,
    output logic          irq_stat
);
    logic wr_addr, wr_count, wr_ctrl;

    assign wr_addr  = reg_wr && (reg_sel == SEL_ADDR);
    assign wr_count = reg_wr && (reg_sel == SEL_COUNT);
    assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    assign start    = wr_ctrl && reg_wdata[CB_START] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_count <= '0;
            dir       <= 1'b0;
            ie        <= 1'b0;
            tmode     <= 1'b0;
            irq_stat  <= 1'b0;
        end else begin
            if (wr_addr && !busy)
                cur_addr <= reg_wdata[AW-1:0];
            else if (move)
                cur_addr <= cur_addr + 1'b1;

            if (wr_count && !busy)
                cur_count <= reg_wdata[CW-1:0];
            else if (move)
                cur_count <= cur_count - 1'b1;

            if (wr_ctrl) begin
                ie <= reg_wdata[CB_IE];
                if (!busy) begin
                    dir   <= reg_wdata[CB_DIR];
                    tmode <= reg_wdata[CB_TMODE];
                end
            end

            if (done)
                irq_stat <= 1'b1;
            else if (wr_ctrl && reg_wdata[CB_IRQ])
                irq_stat <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_ADDR:  reg_rdata = DW'(cur_addr);
            SEL_COUNT: reg_rdata = DW'(cur_count);
            SEL_CTRL: begin
                reg_rdata[CB_DIR]   = dir;
                reg_rdata[CB_IE]    = ie;
                reg_rdata[CB_TMODE] = tmode;
                reg_rdata[CB_IRQ]   = irq_stat;
                reg_rdata[CB_BUSY]  = busy;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
#(
    parameter int CW        = 16,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic          bus_grant,
    input  logic          bus_idle,
    input  logic          tmode,
    output logic          bus_req,
    output logic          busy,
    output logic          move,
    output logic          done
);
    localparam int BCW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BCW-1:0] LAST_BEAT = BCW'(BURST_LEN - 1);

    dma_state_e state_q, state_d;
    logic [BCW-1:0] beat_q;
    logic last_word, last_beat;

    assign last_word = (count == CW'(1));
    assign last_beat = (beat_q == LAST_BEAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_BURST)
                beat_q <= '0;
            else if (move)
                beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && count != '0) state_d = ST_REQ;
            ST_REQ:   if (bus_grant) state_d = ST_BURST;
            ST_BURST: begin
                if (move && last_word)      state_d = ST_IDLE;
                else if (move && last_beat) state_d = ST_GAP;
            end
            ST_GAP:   state_d = ST_REQ;
        endcase
    end

    always_comb begin
        bus_req = 1'b0;
        move    = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                done = start && (count == '0);
            end
            ST_REQ:   bus_req = 1'b1;
            ST_BURST: begin
                bus_req = 1'b1;
                move    = bus_grant && (!tmode || bus_idle);
                done    = move && last_word;
            end
            ST_GAP:   bus_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_xfer_path.sv
module dma_xfer_path #(
    parameter int DW = 32
) (
    input  logic          dir,
    input  logic          move,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] io_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          io_rd,
    output logic          io_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] io_wdata
);
    always_comb begin
        mem_rd    = move && dir;
        io_wr     = move && dir;
        io_rd     = move && !dir;
        mem_wr    = move && !dir;
        io_wdata  = mem_rdata;
        mem_wdata = io_rdata;
    end
endmodule

// File: rtl/burst_dma_channel.sv
module burst_dma_channel #(
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int DW        = 32,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          bus_req,
    input  logic          bus_grant,
    input  logic          bus_idle,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          io_rd,
    output logic          io_wr,
    output logic [DW-1:0] io_wdata,
    input  logic [DW-1:0] io_rdata,
    output logic          irq
);
    logic          start_w, busy_w, move_w, done_w;
    logic          dir_w, ie_w, tmode_w, irq_stat_w;
    logic [CW-1:0] count_w;

    dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy_w),
        .move      (move_w),
        .done      (done_w),
        .start     (start_w),
        .cur_addr  (mem_addr),
        .cur_count (count_w),
        .dir       (dir_w),
        .ie        (ie_w),
        .tmode     (tmode_w),
        .irq_stat  (irq_stat_w)
    );

    dma_fsm #(.CW(CW), .BURST_LEN(BURST_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .count     (count_w),
        .bus_grant (bus_grant),
        .bus_idle  (bus_idle),
        .tmode     (tmode_w),
        .bus_req   (bus_req),
        .busy      (busy_w),
        .move      (move_w),
        .done      (done_w)
    );

    dma_xfer_path #(.DW(DW)) u_path (
        .dir       (dir_w),
        .move      (move_w),
        .mem_rdata (mem_rdata),
        .io_rdata  (io_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .mem_wdata (mem_wdata),
        .io_wdata  (io_wdata)
    );

    assign irq = irq_stat_w && ie_w;
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
    parameter int CW        = 16,
    parameter int BURST_LEN = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_grant,
    input logic          bus_idle,
    input logic          tmode,
    input logic          busy,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [CW-1:0] count,
    input logic          irq_stat
);
    localparam int RW = $clog2(BURST_LEN + 2);

    logic          moving;
    logic [RW-1:0] run_q;

    assign moving = mem_rd || mem_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (!bus_req)
            run_q <= '0;
        else if (moving)
            run_q <= run_q + 1'b1;
    end

    // R3
    move_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        moving |-> (bus_grant && bus_req));

    // R4
    burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(BURST_LEN));

    // R5
    idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && tmode) |-> bus_idle);

    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_stat) && $past(busy)) |-> (!busy && !bus_req));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (count == $past(count) || count == $past(count) - 1'b1));
endmodule

bind burst_dma_channel dma_chk #(.CW(CW), .BURST_LEN(BURST_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .bus_idle  (bus_idle),
    .tmode     (tmode_w),
    .busy      (busy_w),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .count     (count_w),
    .irq_stat  (irq_stat_w)
);

// File: tb/burst_dma_channel_bench.sv
module burst_dma_channel_bench;
    localparam int AW = 16, CW = 16, DW = 32, BL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          bus_req, bus_grant;
    logic          bus_idle = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr, io_rd, io_wr, irq;
    logic [DW-1:0] mem_wdata, mem_rdata, io_wdata, io_rdata;

    logic grant_en = 1'b1, idle_tog = 1'b0, tmode_test = 1'b0, mon_clr = 1'b0;
    int   errors = 0, checks = 0;
    int   io_wr_cnt = 0, io_rd_cnt = 0, moves = 0, run = 0, max_run = 0;
    int   req_falls = 0, req_rises = 0, viol = 0;
    logic req_prev = 1'b0;
    logic [DW-1:0] io_log [0:63];
    logic [DW-1:0] wmem [0:63];

    always #2 clk = ~clk;

    assign bus_grant = bus_req && grant_en;
    assign mem_rdata = 32'hC0DE_0000 | DW'(mem_addr);
    assign io_rdata  = 32'hA000_0000 + DW'(io_rd_cnt);

    burst_dma_channel #(.AW(AW), .CW(CW), .DW(DW), .BURST_LEN(BL)) u_burst_dma_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_idle(bus_idle), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq)
    );

    always @(negedge clk) begin
        if (idle_tog) bus_idle <= ~bus_idle;
        else          bus_idle <= 1'b1;
    end

    always @(posedge clk) begin
        if (io_wr) begin
            io_log[io_wr_cnt[5:0]] <= io_wdata;
            io_wr_cnt <= io_wr_cnt + 1;
        end
        if (io_rd) io_rd_cnt <= io_rd_cnt + 1;
        if (mem_wr) wmem[mem_addr[5:0]] <= mem_wdata;
        if (io_wr || mem_wr) moves <= moves + 1;
        if (tmode_test && (io_wr || mem_wr) && !bus_idle) viol <= viol + 1;
        if (req_prev && !bus_req) req_falls <= req_falls + 1;
        if (!req_prev && bus_req) req_rises <= req_rises + 1;
        req_prev <= bus_req;
        if (mon_clr) begin
            run <= 0; max_run <= 0;
        end else if (io_wr || mem_wr) begin
            run <= run + 1;
            if (run + 1 > max_run) max_run <= run + 1;
        end else begin
            run <= 0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd_reg(2'd2, v);
            if (!v[5]) break;
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 3; s++) begin
            rd_reg(2'(s), v);
            check(v == 0, "R1 register reset", v, 0);
        end
        check({bus_req, irq, mem_rd, mem_wr, io_rd, io_wr} == 0, "R1 outputs reset",
              {26'd0, bus_req, irq, mem_rd, mem_wr, io_rd, io_wr}, 0);
    endtask

    task automatic t_mem_to_io();
        logic [31:0] v;
        int base, falls0;
        pulse_clr();
        base = io_wr_cnt; falls0 = req_falls;
        wr_reg(2'd0, 32'd4);
        wr_reg(2'd1, 32'd10);
        wr_reg(2'd2, 32'h7);
        wait_idle();
        for (int i = 0; i < 10; i++)
            check(io_log[(base + i) % 64] == (32'hC0DE_0000 | (4 + i)), "R2 mem to io data",
                  io_log[(base + i) % 64], 32'hC0DE_0000 | (4 + i));
        rd_reg(2'd0, v); check(v == 14, "R2 address advanced", v, 14);
        rd_reg(2'd1, v); check(v == 0, "R2 count exhausted", v, 0);
        check(max_run == BL, "R4 burst length", max_run, BL);
        check(req_falls - falls0 == 3, "R4 request drops", req_falls - falls0, 3);
        rd_reg(2'd2, v);
        check(v[5:4] == 2'b01, "R6 idle with status", v, 32'h10);
        check(bus_req == 1'b0, "R6 request released", bus_req, 0);
        check(irq == 1'b1, "R7 irq when enabled", irq, 1);
        wr_reg(2'd2, 32'h14);
        check(irq == 1'b0, "R7 status cleared", irq, 0);
    endtask

    task automatic t_io_to_mem_nogrant();
        logic [31:0] v;
        int rb, mv0;
        rb = io_rd_cnt; mv0 = moves;
        grant_en = 1'b0;
        wr_reg(2'd0, 32'd32);
        wr_reg(2'd1, 32'd5);
        wr_reg(2'd2, 32'h1);
        check(bus_req == 1'b1, "R3 request after start", bus_req, 1);
        repeat (20) @(negedge clk);
        check(moves == mv0, "R3 no move without grant", moves - mv0, 0);
        grant_en = 1'b1;
        wait_idle();
        for (int i = 0; i < 5; i++)
            check(wmem[32 + i] == 32'hA000_0000 + rb + i, "R2 io to mem data",
                  wmem[32 + i], 32'hA000_0000 + rb + i);
        rd_reg(2'd2, v);
        check(v[4] == 1'b1 && irq == 1'b0, "R7 status set, irq masked", {v[4], irq}, 2'b10);
        wr_reg(2'd2, 32'h4);
        check(irq == 1'b1, "R7 enable raises irq", irq, 1);
        wr_reg(2'd2, 32'h10);
        rd_reg(2'd2, v);
        check(v[4] == 1'b0 && irq == 1'b0, "R7 write one clears", v, 0);
    endtask

    task automatic t_transparent();
        int rb;
        rb = io_rd_cnt;
        tmode_test = 1'b1; idle_tog = 1'b1;
        wr_reg(2'd0, 32'd40);
        wr_reg(2'd1, 32'd6);
        wr_reg(2'd2, 32'h9);
        wait_idle();
        idle_tog = 1'b0;
        @(negedge clk); tmode_test = 1'b0;
        check(viol == 0, "R5 moves only on idle bus", viol, 0);
        for (int i = 0; i < 6; i++)
            check(wmem[40 + i] == 32'hA000_0000 + rb + i, "R5 transparent data",
                  wmem[40 + i], 32'hA000_0000 + rb + i);
        wr_reg(2'd2, 32'h10);
    endtask

    task automatic t_ignore_writes();
        logic [31:0] v;
        int base;
        base = io_wr_cnt;
        wr_reg(2'd0, 32'd16);
        wr_reg(2'd1, 32'd8);
        wr_reg(2'd2, 32'h3);
        wr_reg(2'd0, 32'd0);
        wr_reg(2'd1, 32'd3);
        wr_reg(2'd2, 32'h8);
        wait_idle();
        rd_reg(2'd0, v); check(v == 24, "R8 address write ignored", v, 24);
        check(io_wr_cnt - base == 8, "R8 count write ignored", io_wr_cnt - base, 8);
        for (int i = 0; i < 8; i++)
            check(io_log[(base + i) % 64] == (32'hC0DE_0000 | (16 + i)), "R8 data intact",
                  io_log[(base + i) % 64], 32'hC0DE_0000 | (16 + i));
        rd_reg(2'd2, v);
        check(v[3] == 1'b0 && v[1] == 1'b1, "R8 mode bits held", v, 32'h12);
        wr_reg(2'd2, 32'h10);
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        int r0;
        r0 = req_rises;
        wr_reg(2'd1, 32'd0);
        wr_reg(2'd2, 32'h5);
        rd_reg(2'd2, v);
        check(v[5:4] == 2'b01, "R9 zero count completes", v, 32'h14);
        check(irq == 1'b1, "R9 irq on zero count", irq, 1);
        repeat (3) @(negedge clk);
        check(req_rises == r0, "R9 no bus request", req_rises - r0, 0);
        wr_reg(2'd2, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mem_to_io();
        t_io_to_mem_nogrant();
        t_transparent();
        t_ignore_writes();
        t_zero_count();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule